// File: doc/BRIEF.md
# Cache Victim Way Selector

This block decides which way of one set of an N-way set-associative cache is evicted on the next refill. The cache pipeline presents the set number being looked up, a strobe when a lookup hits together with the way that hit, a strobe when a miss consumes a victim, and the valid bits of the addressed set. The block answers with the victim way for that set as combinational logic of its stored state and these inputs. Tags, data and the refill itself stay outside.

A two-bit policy input chooses among four replacement schemes: a free-running pseudo-random pick, a binary-tree pseudo-LRU (exact LRU when the cache has two ways), a round-robin pointer, and a round-robin pointer that steps over the most recently touched way. Every set keeps its own tree bits, round-robin pointer and last-touched way, so the policy input may change at run time without any state being reinitialised. Associativity is 2, 4 or 8 ways. The set count is a power of two of at least 2.

Top module: `cache_victim_sel`

## Requirements
- R1: After reset, every set has tree bits, round-robin pointer and last-touched way all at zero. With a full set this gives victim 0 in tree and round-robin modes and victim 1 in skip-recent mode.
- R2: When any valid bit of the addressed set is 0, the victim is the lowest-numbered way whose valid bit is 0, whatever the policy.
- R3: The policy input is decoded as 0 = pseudo-random, 1 = tree pseudo-LRU, 2 = round-robin, 3 = round-robin skipping the last-touched way.
- R4: In tree mode each internal node holds one bit, and 0 sends the victim search to the lower-numbered half. A touch of way w sets every node on w's path to point at the half that does not contain w. With 4 ways, node 0 splits {0,1} from {2,3}, node 1 splits 0 from 1, and node 2 splits 2 from 3.
- R5: Recency state (tree bits and last-touched way) is updated on every touch. A hit touches the way on hitWay. A miss touches the victim that was output in that cycle. When the miss strobe is high, hitWay is ignored.
- R6: The round-robin pointer of a set moves only on a miss to that set. In modes 0, 1 and 2 it moves to pointer+1, modulo the way count. Hits leave it unchanged.
- R7: In skip-recent mode the candidate is the pointer, unless the pointer equals the last-touched way, in which case the candidate is pointer+1. A miss in this mode moves the pointer to candidate+1.
- R8: In random mode with a full set, the victim is taken from the low bits of an internal 16-bit LFSR that advances every clock cycle. Successive misses therefore land on more than one way.
- R9: State is kept per set. An access to one set leaves the victim of every other set unchanged.
- R10: In a cycle with neither strobe high, no per-set state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| policySel | input | 2 | Replacement policy code (R3) |
| setIdx | input | log2(NUM_SETS) | Set being looked up |
| accessValid | input | 1 | A lookup hit on way hitWay this cycle |
| hitWay | input | log2(NUM_WAYS) | Way that hit |
| missValid | input | 1 | A miss consumes victimWay this cycle |
| validBits | input | NUM_WAYS | Valid bits of the addressed set |
| victimWay | output | log2(NUM_WAYS) | Chosen victim way |

## Verification
The bound checker checks four rules on every cycle. A set with a free way must name the lowest free way. After a hit, tree and skip-recent modes must not name the way just hit when the next cycle addresses the same full set. A round-robin miss must advance the victim by one on the same set. An idle cycle must leave the victim of a full set unchanged in deterministic modes. The rules that hold over long histories can only be shown by the bench's scenarios, which compare the outputs against a behavioural model of each set. These cover the exact tree bit pattern after mixed hits and misses, the independence of sets, the reset state, and the spread of random victims.

// File: rtl/victim_sel_pkg.sv
package victim_sel_pkg;

  typedef enum logic [1:0] {
    POL_RANDOM = 2'd0,
    POL_TREE   = 2'd1,
    POL_ROUND  = 2'd2,
    POL_SKIP   = 2'd3
  } replPolicyE;

  typedef struct packed {
    logic touch;    // update recency state with touchWay
    logic advance;  // move the round-robin pointer
    logic skipMru;  // pointer move follows the skip-recent candidate
  } replStrobeT;

endpackage

// File: rtl/victim_ctrl.sv
module victim_ctrl
  import victim_sel_pkg::*;
#(
  parameter int WAY_W = 2
) (
  input  replPolicyE         policy,
  input  logic               accessValid,
  input  logic               missValid,
  input  logic [WAY_W-1:0]   hitWay,
  input  logic [WAY_W-1:0]   victimWay,
  output replStrobeT         strobe,
  output logic [WAY_W-1:0]   touchWay
);

  always_comb begin
    strobe.touch   = accessValid | missValid;
    strobe.advance = missValid;
    strobe.skipMru = (policy == POL_SKIP);
    // A miss refills the victim, so that way becomes the most recent one.
    touchWay = missValid ? victimWay : hitWay;
  end

endmodule

// File: rtl/victim_data.sv
module victim_data
  import victim_sel_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  replPolicyE                   policy,
  input  logic [$clog2(NUM_SETS)-1:0]  setIdx,
  input  logic [NUM_WAYS-1:0]          validBits,
  input  replStrobeT                   strobe,
  input  logic [$clog2(NUM_WAYS)-1:0]  touchWay,
  output logic [$clog2(NUM_WAYS)-1:0]  victimWay
);

  localparam int WAY_W  = $clog2(NUM_WAYS);
  localparam int TREE_W = NUM_WAYS - 1;

  logic [TREE_W-1:0] treeQ [NUM_SETS];
  logic [WAY_W-1:0]  ptrQ  [NUM_SETS];
  logic [WAY_W-1:0]  mruQ  [NUM_SETS];
  logic [15:0]       lfsrQ;

  logic [TREE_W-1:0] curTree;
  logic [TREE_W-1:0] nextTree;
  logic [WAY_W-1:0]  treePick;
  logic [WAY_W-1:0]  ptrPick;
  logic [WAY_W-1:0]  skipPick;
  logic [WAY_W-1:0]  policyPick;
  logic [WAY_W-1:0]  freeIdx;
  logic              hasFree;

  assign curTree = treeQ[setIdx];
  assign ptrPick = ptrQ[setIdx];
  assign skipPick = (ptrPick == mruQ[setIdx]) ? ptrPick + WAY_W'(1) : ptrPick;

  // Tree walk: a 2-way set is a single bit and is exact LRU.
  generate
    if (NUM_WAYS == 2) begin : g_pair
      always_comb begin
        treePick = curTree[0];
        nextTree = ~touchWay;
      end
    end else begin : g_tree
      always_comb begin
        logic [WAY_W-1:0] node;
        logic             goRight;
        node     = '0;
        treePick = '0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
          goRight = curTree[node];
          treePick[WAY_W-1-lvl] = goRight;
          node = {node[WAY_W-2:0], 1'b0} + WAY_W'(1) + WAY_W'(goRight);
        end
      end

      always_comb begin
        logic [WAY_W-1:0] node;
        logic             inRight;
        node     = '0;
        nextTree = curTree;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
          inRight = touchWay[WAY_W-1-lvl];
          nextTree[node] = ~inRight;
          node = {node[WAY_W-2:0], 1'b0} + WAY_W'(1) + WAY_W'(inRight);
        end
      end
    end
  endgenerate

  // Lowest free way wins over any policy.
  always_comb begin
    hasFree = ~&validBits;
    freeIdx = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (!validBits[i]) freeIdx = WAY_W'(i);
    end
  end

  always_comb begin
    unique case (policy)
      POL_RANDOM: policyPick = lfsrQ[WAY_W-1:0];
      POL_TREE:   policyPick = treePick;
      POL_ROUND:  policyPick = ptrPick;
      POL_SKIP:   policyPick = skipPick;
      default:    policyPick = ptrPick;
    endcase
    victimWay = hasFree ? freeIdx : policyPick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ <= LFSR_SEED;
    end else begin
      lfsrQ <= {1'b0, lfsrQ[15:1]} ^ (lfsrQ[0] ? 16'hB400 : 16'h0000);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        treeQ[s] <= '0;
        ptrQ[s]  <= '0;
        mruQ[s]  <= '0;
      end
    end else begin
      if (strobe.touch) begin
        treeQ[setIdx] <= nextTree;
        mruQ[setIdx]  <= touchWay;
      end
      if (strobe.advance) begin
        ptrQ[setIdx] <= strobe.skipMru ? skipPick + WAY_W'(1) : ptrPick + WAY_W'(1);
      end
    end
  end

endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel
  import victim_sel_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         policySel,
  input  logic [SET_W-1:0]   setIdx,
  input  logic               accessValid,
  input  logic [WAY_W-1:0]   hitWay,
  input  logic               missValid,
  input  logic [NUM_WAYS-1:0] validBits,
  output logic [WAY_W-1:0]   victimWay
);

  replPolicyE       policy;
  replStrobeT       strobe;
  logic [WAY_W-1:0] touchWay;

  assign policy = replPolicyE'(policySel);

  victim_ctrl #(.WAY_W(WAY_W)) u_ctrl (
    .policy      (policy),
    .accessValid (accessValid),
    .missValid   (missValid),
    .hitWay      (hitWay),
    .victimWay   (victimWay),
    .strobe      (strobe),
    .touchWay    (touchWay)
  );

  victim_data #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .policy    (policy),
    .setIdx    (setIdx),
    .validBits (validBits),
    .strobe    (strobe),
    .touchWay  (touchWay),
    .victimWay (victimWay)
  );

endmodule

// File: rtl/cache_victim_sel_chk.sv
module cache_victim_sel_chk #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          policySel,
  input logic [SET_W-1:0]    setIdx,
  input logic                accessValid,
  input logic [WAY_W-1:0]    hitWay,
  input logic                missValid,
  input logic [NUM_WAYS-1:0] validBits,
  input logic [WAY_W-1:0]    victimWay
);

  logic [NUM_WAYS-1:0] belowMask;
  logic                fullSet;
  assign belowMask = (NUM_WAYS'(1) << victimWay) - NUM_WAYS'(1);
  assign fullSet   = &validBits;

  // R2: lowest free way is chosen
  assert_free_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    !fullSet |-> (!validBits[victimWay] && ((validBits & belowMask) == belowMask)));

  // R4, R7: tree and skip-recent modes never name the way just hit
  assert_not_just_hit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fullSet && (policySel == 2'd1 || policySel == 2'd3) &&
     $past(accessValid && !missValid) && setIdx == $past(setIdx))
    |-> victimWay != $past(hitWay));

  // R6: round-robin miss steps the victim by one
  assert_round_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fullSet && $past(fullSet) && policySel == 2'd2 && $past(policySel) == 2'd2 &&
     $past(missValid) && setIdx == $past(setIdx))
    |-> victimWay == WAY_W'($past(victimWay) + 1'b1));

  // R10: idle cycle changes nothing visible
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (fullSet && $past(fullSet) && policySel != 2'd0 && $stable(policySel) &&
     $stable(setIdx) && $past(!accessValid && !missValid))
    |-> $stable(victimWay));

endmodule

bind cache_victim_sel cache_victim_sel_chk #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .policySel   (policySel),
  .setIdx      (setIdx),
  .accessValid (accessValid),
  .hitWay      (hitWay),
  .missValid   (missValid),
  .validBits   (validBits),
  .victimWay   (victimWay)
);

// File: tb/cache_victim_sel_tb.sv
`timescale 1ns/1ps
module cache_victim_sel_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] policySel = 2'd0;
  logic [3:0] setIdx = '0;
  logic       accessValid = 1'b0;
  logic [1:0] hitWay = '0;
  logic       missValid = 1'b0;
  logic [3:0] validBits = 4'hF;
  logic [1:0] victimWay;

  int vectors = 0;
  int fails = 0;
  bit seen [4];

  logic [2:0] mTree [16];
  logic [1:0] mPtr  [16];
  logic [1:0] mMru  [16];

  always #5 clk = ~clk;

  cache_victim_sel #(.NUM_WAYS(4), .NUM_SETS(16)) u_dut (
    .clk(clk), .rstN(rstN), .policySel(policySel), .setIdx(setIdx),
    .accessValid(accessValid), .hitWay(hitWay), .missValid(missValid),
    .validBits(validBits), .victimWay(victimWay)
  );

  function automatic logic [1:0] treeVictim(logic [2:0] t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    return t[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [2:0] treeTouch(logic [2:0] t, logic [1:0] w);
    logic [2:0] r = t;
    if (w < 2) begin r[0] = 1'b1; r[1] = (w == 2'd0); end
    else       begin r[0] = 1'b0; r[2] = (w == 2'd2); end
    return r;
  endfunction

  function automatic logic [1:0] skipVictim(int s);
    return (mPtr[s] == mMru[s]) ? mPtr[s] + 2'd1 : mPtr[s];
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: victim actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic op(int mode, int s, bit acc, bit miss, logic [1:0] hw,
                    logic [3:0] vb, string req);
    logic [1:0] exp, got, tw;
    bit known;
    @(negedge clk);
    policySel = mode[1:0]; setIdx = s[3:0]; accessValid = acc;
    missValid = miss; hitWay = hw; validBits = vb;
    #1;
    got = victimWay;
    known = 1'b1;
    exp = 2'd0;
    if (vb != 4'hF) begin
      for (int i = 3; i >= 0; i--) if (!vb[i]) exp = 2'(i);
    end else begin
      case (mode)
        1: exp = treeVictim(mTree[s]);
        2: exp = mPtr[s];
        3: exp = skipVictim(s);
        default: known = 1'b0;
      endcase
    end
    if (known) chk(req, got, exp);
    else seen[got] = 1'b1;
    @(posedge clk);
    if (acc || miss) begin
      tw = miss ? got : hw;
      if (miss) mPtr[s] = (mode == 3) ? skipVictim(s) + 2'd1 : mPtr[s] + 2'd1;
      mTree[s] = treeTouch(mTree[s], tw);
      mMru[s] = tw;
    end
    @(negedge clk);
    accessValid = 1'b0; missValid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < 16; s++) begin mTree[s] = '0; mPtr[s] = '0; mMru[s] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state, R3 mode codes
    op(1, 5, 0, 0, 0, 4'hF, "R1 tree reset");
    op(2, 5, 0, 0, 0, 4'hF, "R1 round reset");
    op(3, 5, 0, 0, 0, 4'hF, "R1 skip reset");

    // R2 free way first in every mode
    for (int m = 0; m < 4; m++) op(m, 2, 0, 0, 0, 4'b1011, "R2 free way");
    op(1, 2, 0, 0, 0, 4'b0000, "R2 empty set");
    op(2, 2, 0, 0, 0, 4'b0110, "R2 lowest free");

    // R6 hits leave pointer; miss steps it; R9 other set untouched
    op(2, 3, 1, 0, 2'd0, 4'hF, "R6 hit no move");
    op(2, 3, 0, 0, 0, 4'hF, "R6 after hit");
    op(2, 3, 0, 1, 0, 4'hF, "R6 miss");
    op(2, 3, 0, 0, 0, 4'hF, "R6 stepped");
    op(2, 4, 0, 0, 0, 4'hF, "R9 other set");

    // R4, R5 tree path and miss priority over hitWay
    op(1, 7, 1, 0, 2'd0, 4'hF, "R4 hit way0");
    op(1, 7, 0, 0, 0, 4'hF, "R4 after way0");
    op(1, 7, 1, 0, 2'd2, 4'hF, "R4 hit way2");
    op(1, 7, 0, 1, 2'd3, 4'hF, "R5 miss touches victim");
    op(1, 7, 0, 0, 0, 4'hF, "R5 after miss");

    // R7 skip-recent
    op(3, 9, 1, 0, 2'd0, 4'hF, "R7 hit on pointer");
    op(3, 9, 0, 1, 0, 4'hF, "R7 skip miss");
    op(3, 9, 0, 0, 0, 4'hF, "R7 pointer after skip");

    // R10 idle cycles
    op(1, 7, 0, 0, 0, 4'hF, "R10 idle");
    op(1, 7, 0, 0, 0, 4'hF, "R10 idle again");

    // R8 random spread
    for (int k = 0; k < 4; k++) seen[k] = 1'b0;
    for (int k = 0; k < 40; k++) op(0, 11, 0, 1, 0, 4'hF, "R8 random");
    begin
      int distinct = 0;
      for (int k = 0; k < 4; k++) if (seen[k]) distinct++;
      vectors++;
      if (distinct < 2) begin
        fails++;
        $display("FAIL R8: distinct ways actual %0d expected >=2", distinct);
      end
    end

    // Mixed random traffic across R4 R5 R6 R7 R9
    for (int n = 0; n < 4000; n++) begin
      int mode = int'($urandom % 4);
      int s = int'($urandom % 16);
      int kind = int'($urandom % 3);
      logic [3:0] vb = ($urandom % 8 == 0) ? 4'($urandom) : 4'hF;
      op(mode, s, kind == 1, kind == 2, 2'($urandom), vb, "R5 R9 random mix");
    end

    summary();
  end

endmodule